// File: doc/BRIEF.md
# DC-Balanced 8b/10b Character Encoder

This block turns one byte per clock into a 10-bit line symbol from the standard 8b/10b code used by Ethernet and Fibre Channel links. Each input character is a byte plus a control flag: with the flag low the byte becomes one of the 256 data symbols, and with the flag high it becomes one of the twelve control symbols used for framing and commas. A running disparity bit is kept across characters, so each symbol is chosen to pull the line back toward an equal count of ones and zeros.

A control request whose byte is not one of the twelve legal control values is reported on an error output. That error is registered together with the symbol it belongs to, and the symbol sent in its place is the ordinary data encoding of the byte, so the line stays balanced. A bypass input routes an already encoded 10-bit word straight to the output. The running disparity is neither used nor changed by a bypassed word. Every output is registered and appears one clock after the input it came from.

Top module: `dcbal_encoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `outValid` and `ctrlErr` and sets the running disparity negative. The first control character 0xBC (K28.5) after reset is therefore encoded as 10'b0011111010.
- R2: `outValid` is `inValid` delayed by one clock. A cycle with `inValid` low gives `outValid` low and `ctrlErr` low, and it leaves the running disparity unchanged.
- R3: With `inCtrl` low and `bypass` low, byte HGFEDCBA (bit 7 = H) is encoded by the standard 5b/6b and 3b/4b sub-block tables. The symbol has bit order `outSymbol[9:0]` = {a,b,c,d,e,i,f,g,h,j}, where a is the bit sent first.
- R4: With `inCtrl` high, the twelve legal control values are 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE. They encode to the standard K28.0–K28.7, K23.7, K27.7, K29.7 and K30.7 symbols for the current disparity, with `ctrlErr` low.
- R5: With `inCtrl` high and any other byte, `ctrlErr` is high in the same cycle as the symbol, and that symbol is the data encoding of the byte. The running disparity advances exactly as it does for data.
- R6: Every encoded symbol holds 4, 5 or 6 ones. A symbol with 6 ones is sent only when the disparity was negative, and it leaves the disparity positive. A symbol with 4 ones is sent only when the disparity was positive, and it leaves the disparity negative. A symbol with 5 ones leaves the disparity unchanged.
- R7: With `bypass` high and `inValid` high, `outSymbol` equals `inRaw` and `ctrlErr` is low, whatever `inCtrl` and `inByte` hold. The running disparity is unchanged, which the next encoded symbol shows.
- R8: For data bytes whose 3b/4b part is 7, the alternate code (0111 or 1000) is used in two cases: 5b part 17, 18 or 20 with negative disparity after the 6-bit sub-block, and 5b part 11, 13 or 14 with positive disparity after it. Every control x.7 symbol also uses the alternate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input character present this cycle |
| inByte | input | 8 | Byte to encode, bit 7 = H, bit 0 = A |
| inCtrl | input | 1 | High requests a control symbol |
| bypass | input | 1 | High passes `inRaw` through unencoded |
| inRaw | input | 10 | Pre-encoded symbol used in bypass |
| outValid | output | 1 | Output symbol valid |
| outSymbol | output | 10 | Encoded or passed-through symbol, {a,b,c,d,e,i,f,g,h,j} |
| ctrlErr | output | 1 | Illegal control request for the symbol now shown |

## Verification
The assertions assume that `inValid`, `bypass` and `inRaw` are stable and known at each rising edge. They also assume that a bypassed word carries no weight meaning, so the ones-count and disparity checks apply only to cycles that were encoded. The bench drives all inputs on the falling edge, so every input settles half a period before the edge that samples it. Its bypass words are chosen freely and are kept out of the weight checks by a flag registered in the checker.

// File: rtl/dcbal_pkg.sv
package dcbal_pkg;

  localparam int ByteW   = 8;
  localparam int SymW    = 10;
  localparam int LowW    = 5;
  localparam int HighW   = ByteW - LowW;
  localparam int SixW    = LowW + 1;
  localparam int FourW   = HighW + 1;
  localparam logic RdResetPos = 1'b0;

  localparam logic [LowW-1:0]  CommaLow = 5'd28;
  localparam logic [HighW-1:0] AltHigh  = 3'd7;

  typedef struct packed {
    logic load;    // capture a character into the output register
    logic encode;  // encoded path (not bypass): advance disparity
    logic kLegal;  // legal control symbol requested
    logic kBad;    // illegal control request
  } dcbal_strobe_t;

  // {unbalanced, flipOnPositive, code in negative-disparity form}
  function automatic logic [SixW+1:0] sixTable(input logic [LowW-1:0] x);
    case (x)
      5'd0:  return {2'b11, 6'b100111};
      5'd1:  return {2'b11, 6'b011101};
      5'd2:  return {2'b11, 6'b101101};
      5'd3:  return {2'b00, 6'b110001};
      5'd4:  return {2'b11, 6'b110101};
      5'd5:  return {2'b00, 6'b101001};
      5'd6:  return {2'b00, 6'b011001};
      5'd7:  return {2'b01, 6'b111000};
      5'd8:  return {2'b11, 6'b111001};
      5'd9:  return {2'b00, 6'b100101};
      5'd10: return {2'b00, 6'b010101};
      5'd11: return {2'b00, 6'b110100};
      5'd12: return {2'b00, 6'b001101};
      5'd13: return {2'b00, 6'b101100};
      5'd14: return {2'b00, 6'b011100};
      5'd15: return {2'b11, 6'b010111};
      5'd16: return {2'b11, 6'b011011};
      5'd17: return {2'b00, 6'b100011};
      5'd18: return {2'b00, 6'b010011};
      5'd19: return {2'b00, 6'b110010};
      5'd20: return {2'b00, 6'b001011};
      5'd21: return {2'b00, 6'b101010};
      5'd22: return {2'b00, 6'b011010};
      5'd23: return {2'b11, 6'b111010};
      5'd24: return {2'b11, 6'b110011};
      5'd25: return {2'b00, 6'b100110};
      5'd26: return {2'b00, 6'b010110};
      5'd27: return {2'b11, 6'b110110};
      5'd28: return {2'b00, 6'b001110};
      5'd29: return {2'b11, 6'b101110};
      5'd30: return {2'b11, 6'b011110};
      default: return {2'b11, 6'b101011};
    endcase
  endfunction

  function automatic logic [FourW+1:0] fourTable(input logic [HighW-1:0] y);
    case (y)
      3'd0: return {2'b11, 4'b1011};
      3'd1: return {2'b00, 4'b1001};
      3'd2: return {2'b00, 4'b0101};
      3'd3: return {2'b01, 4'b1100};
      3'd4: return {2'b11, 4'b1101};
      3'd5: return {2'b00, 4'b1010};
      3'd6: return {2'b00, 4'b0110};
      default: return {2'b11, 4'b1110};
    endcase
  endfunction

endpackage

// File: rtl/dcbal_ctrl.sv
module dcbal_ctrl
  import dcbal_pkg::*;
(
  input  logic             inValid,
  input  logic             inCtrl,
  input  logic             bypass,
  input  logic [ByteW-1:0] inByte,
  output dcbal_strobe_t    strb
);

  logic isComma;
  logic isAltK;
  logic legal;

  always_comb begin
    isComma = (inByte[LowW-1:0] == CommaLow);
    isAltK  = (inByte == 8'hF7) || (inByte == 8'hFB) ||
              (inByte == 8'hFD) || (inByte == 8'hFE);
    legal   = isComma || isAltK;

    strb.load   = inValid;
    strb.encode = inValid && !bypass;
    strb.kLegal = inCtrl && legal;
    strb.kBad   = inValid && !bypass && inCtrl && !legal;
  end

endmodule

// File: rtl/dcbal_path.sv
module dcbal_path
  import dcbal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  dcbal_strobe_t    strb,
  input  logic [ByteW-1:0] inByte,
  input  logic [SymW-1:0]  inRaw,
  output logic             outValid,
  output logic [SymW-1:0]  outSymbol,
  output logic             ctrlErr,
  output logic             rdPos
);

  logic [LowW-1:0]  xPart;
  logic [HighW-1:0] yPart;
  logic             commaK;
  logic [SixW+1:0]  sixEntry;
  logic [FourW+1:0] fourEntry;
  logic [SixW-1:0]  sixCode;
  logic [FourW-1:0] fourCode;
  logic             sixUnbal;
  logic             sixFlip;
  logic             fourUnbal;
  logic             fourFlip;
  logic             rdMid;
  logic             useAlt;
  logic             neutralY;
  logic             nextRd;
  logic [SymW-1:0]  encSym;

  always_comb begin
    xPart  = inByte[LowW-1:0];
    yPart  = inByte[ByteW-1:LowW];
    commaK = strb.kLegal && (xPart == CommaLow);

    // 5b/6b sub-block
    sixEntry = commaK ? {2'b11, 6'b001111} : sixTable(xPart);
    sixUnbal = sixEntry[SixW+1];
    sixFlip  = sixEntry[SixW];
    sixCode  = (sixFlip && rdPos) ? ~sixEntry[SixW-1:0] : sixEntry[SixW-1:0];
    rdMid    = rdPos ^ sixUnbal;

    // 3b/4b sub-block with alternate x.7 choice
    useAlt = (yPart == AltHigh) &&
             (strb.kLegal ||
              (!rdMid && (xPart == 5'd17 || xPart == 5'd18 || xPart == 5'd20)) ||
              ( rdMid && (xPart == 5'd11 || xPart == 5'd13 || xPart == 5'd14)));
    fourEntry = useAlt ? {2'b11, 4'b0111} : fourTable(yPart);
    fourUnbal = fourEntry[FourW+1];
    fourFlip  = fourEntry[FourW];
    fourCode  = (fourFlip && rdMid) ? ~fourEntry[FourW-1:0] : fourEntry[FourW-1:0];
    neutralY  = (yPart == 3'd1) || (yPart == 3'd2) || (yPart == 3'd5) || (yPart == 3'd6);
    if (commaK && neutralY && !rdMid) fourCode = ~fourCode;

    nextRd = rdMid ^ fourUnbal;
    encSym = {sixCode, fourCode};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outSymbol <= '0;
      ctrlErr   <= 1'b0;
      rdPos     <= RdResetPos;
    end else begin
      outValid <= strb.load;
      ctrlErr  <= strb.kBad;
      if (strb.load) outSymbol <= strb.encode ? encSym : inRaw;
      if (strb.encode) rdPos <= nextRd;
    end
  end

endmodule

// File: rtl/dcbal_encoder.sv
module dcbal_encoder
  import dcbal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [ByteW-1:0] inByte,
  input  logic             inCtrl,
  input  logic             bypass,
  input  logic [SymW-1:0]  inRaw,
  output logic             outValid,
  output logic [SymW-1:0]  outSymbol,
  output logic             ctrlErr
);

  dcbal_strobe_t strb;
  logic          rdState;

  dcbal_ctrl u_ctrl (
    .inValid (inValid),
    .inCtrl  (inCtrl),
    .bypass  (bypass),
    .inByte  (inByte),
    .strb    (strb)
  );

  dcbal_path u_path (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .inByte    (inByte),
    .inRaw     (inRaw),
    .outValid  (outValid),
    .outSymbol (outSymbol),
    .ctrlErr   (ctrlErr),
    .rdPos     (rdState)
  );

endmodule

// File: rtl/dcbal_encoder_checker.sv
module dcbal_encoder_checker
  import dcbal_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            inValid,
  input logic            bypass,
  input logic [SymW-1:0] inRaw,
  input logic            outValid,
  input logic [SymW-1:0] outSymbol,
  input logic            ctrlErr,
  input logic            rdPos
);

  logic wasBypass;
  always_ff @(posedge clk) begin
    if (rst) wasBypass <= 1'b0;
    else     wasBypass <= inValid && bypass;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!outValid && !ctrlErr && !rdPos));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !ctrlErr && $stable(rdPos)));

  assert_err_with_symbol_R5: assert property (@(posedge clk) disable iff (rst)
    ctrlErr |-> outValid);

  assert_weight_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !wasBypass) |->
      ($countones(outSymbol) >= 4 && $countones(outSymbol) <= 6));

  assert_heavy_needs_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !wasBypass && $countones(outSymbol) == 6) |-> (!$past(rdPos) && rdPos));

  assert_light_needs_pos_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !wasBypass && $countones(outSymbol) == 4) |-> ($past(rdPos) && !rdPos));

  assert_neutral_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !wasBypass && $countones(outSymbol) == 5) |-> (rdPos == $past(rdPos)));

  assert_bypass_raw_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && bypass) |=> (outSymbol == $past(inRaw) && !ctrlErr && $stable(rdPos)));

endmodule

bind dcbal_encoder dcbal_encoder_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .bypass    (bypass),
  .inRaw     (inRaw),
  .outValid  (outValid),
  .outSymbol (outSymbol),
  .ctrlErr   (ctrlErr),
  .rdPos     (rdState)
);

// File: tb/dcbal_encoder_bench.sv
module dcbal_encoder_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic       inCtrl = 1'b0;
  logic       bypass = 1'b0;
  logic [9:0] inRaw = '0;
  logic       outValid;
  logic [9:0] outSymbol;
  logic       ctrlErr;

  int  vecs = 0;
  int  fails = 0;
  bit  done = 0;
  logic modelRd = 1'b0;

  always #4 clk = ~clk;

  dcbal_encoder u_dcbal_encoder (
    .clk(clk), .rst(rst), .inValid(inValid), .inByte(inByte), .inCtrl(inCtrl),
    .bypass(bypass), .inRaw(inRaw), .outValid(outValid), .outSymbol(outSymbol),
    .ctrlErr(ctrlErr)
  );

  function automatic logic [5:0] ref6(input logic [4:0] x);
    logic [5:0] t [32];
    t = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001, 6'b011001, 6'b111000,
          6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
          6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
          6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
    return t[x];
  endfunction

  function automatic logic [3:0] ref4(input logic [2:0] y);
    logic [3:0] t [8];
    t = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    return t[y];
  endfunction

  function automatic bit legalK(input logic [7:0] b);
    return (b[4:0] == 5'd28) || b == 8'hF7 || b == 8'hFB || b == 8'hFD || b == 8'hFE;
  endfunction

  // returns {disparity after, symbol}
  function automatic logic [10:0] refEnc(input logic [7:0] b, input logic k, input logic rdIn);
    logic [4:0] x;
    logic [2:0] y;
    logic kEff, k28, rd6, rd4, alt;
    logic [5:0] s6;
    logic [3:0] s4;
    int c;
    x = b[4:0];
    y = b[7:5];
    kEff = k && legalK(b);
    k28 = kEff && x == 5'd28;
    s6 = k28 ? 6'b001111 : ref6(x);
    if (rdIn && ($countones(s6) != 3 || (!k28 && x == 5'd7))) s6 = ~s6;
    c = $countones(s6);
    rd6 = (c > 3) ? 1'b1 : (c < 3) ? 1'b0 : rdIn;
    alt = (y == 3'd7) && (kEff || (!rd6 && (x == 17 || x == 18 || x == 20)) ||
                          (rd6 && (x == 11 || x == 13 || x == 14)));
    s4 = alt ? 4'b0111 : ref4(y);
    if (rd6 && ($countones(s4) != 2 || y == 3'd3)) s4 = ~s4;
    if (k28 && !rd6 && $countones(s4) == 2 && y != 3'd3) s4 = ~s4;
    c = $countones(s4);
    rd4 = (c > 2) ? 1'b1 : (c < 2) ? 1'b0 : rd6;
    return {rd4, s6, s4};
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic apply(input logic v, input logic [7:0] b, input logic k,
                       input logic byp, input logic [9:0] raw, input string tag);
    logic [10:0] r;
    logic [9:0] expSym;
    logic expErr;
    logic rdBefore;
    @(negedge clk);
    inValid = v; inByte = b; inCtrl = k; bypass = byp; inRaw = raw;
    rdBefore = modelRd;
    expSym = raw;
    expErr = 1'b0;
    if (v && !byp) begin
      r = refEnc(b, k, modelRd);
      expSym = r[9:0];
      expErr = k && !legalK(b);
      modelRd = r[10];
    end
    @(posedge clk);
    #2;
    vecs++;
    if (outValid !== v) fail(tag, "outValid", int'(outValid), int'(v));
    else if (ctrlErr !== expErr) fail(tag, "ctrlErr", int'(ctrlErr), int'(expErr));
    else if (v && outSymbol !== expSym) fail(tag, "outSymbol", int'(outSymbol), int'(expSym));
    if (v && !byp) begin
      int ones;
      ones = $countones(outSymbol);
      vecs++;
      if (!(ones == 5 || (ones == 6 && !rdBefore) || (ones == 4 && rdBefore)))
        fail("R6", "ones", ones, rdBefore ? 4 : 6);
    end
  endtask

  task automatic forceRd(input logic want);
    if (modelRd != want) apply(1'b1, 8'h03, 1'b0, 1'b0, 10'h0, "R3");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    logic [7:0] kList [12];
    kList = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
              8'hF7, 8'hFB, 8'hFD, 8'hFE};

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    vecs++;
    if (outValid !== 1'b0 || ctrlErr !== 1'b0)
      fail("R1", "reset outputs", int'({outValid, ctrlErr}), 0);
    @(negedge clk);
    rst = 1'b0;
    modelRd = 1'b0;
    apply(1'b1, 8'hBC, 1'b1, 1'b0, 10'h0, "R1");
    vecs++;
    if (outSymbol !== 10'b0011111010) fail("R1", "first K28.5", int'(outSymbol), 10'h0FA);

    // R3 / R8: every data byte from both disparities
    for (int b = 0; b < 256; b++) begin
      for (int d = 0; d < 2; d++) begin
        logic [4:0] x;
        x = b[4:0];
        forceRd(d[0]);
        if (b[7:5] == 3'd7 && (x == 11 || x == 13 || x == 14 || x == 17 || x == 18 || x == 20))
          apply(1'b1, b[7:0], 1'b0, 1'b0, 10'h0, "R8");
        else
          apply(1'b1, b[7:0], 1'b0, 1'b0, 10'h0, "R3");
      end
    end

    // R4: legal control symbols from both disparities
    for (int i = 0; i < 12; i++) begin
      for (int d = 0; d < 2; d++) begin
        forceRd(d[0]);
        apply(1'b1, kList[i], 1'b1, 1'b0, 10'h0, "R4");
      end
    end

    // R5: illegal control requests, disparity continues as data
    for (int b = 0; b < 256; b++) begin
      if (!legalK(b[7:0])) apply(1'b1, b[7:0], 1'b1, 1'b0, 10'h0, "R5");
    end

    // R7: bypass words, including illegal control bytes; next encode shows disparity held
    for (int i = 0; i < 64; i++) begin
      apply(1'b1, 8'h00, i[0], 1'b1, 10'((i * 37 + 5) % 1024), "R7");
      apply(1'b1, 8'h03, 1'b0, 1'b0, 10'h0, "R7");
    end

    // R2: idle cycles between characters
    for (int i = 0; i < 8; i++) begin
      apply(1'b0, 8'hFF, 1'b1, 1'b0, 10'h3FF, "R2");
      apply(1'b1, 8'(i * 29 + 1), 1'b0, 1'b0, 10'h0, "R2");
    end

    // R1: reset mid-stream returns disparity to negative
    forceRd(1'b1);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    modelRd = 1'b0;
    apply(1'b1, 8'hBC, 1'b1, 1'b0, 10'h0, "R1");
    vecs++;
    if (outSymbol !== 10'b0011111010) fail("R1", "K28.5 after reset", int'(outSymbol), 10'h0FA);

    finishRun();
  end

endmodule